// File: doc/BRIEF.md
# Multi-mode host register interface

This block is a slave-side host port. A microprocessor uses it to reach a small internal register bank. Three bus styles are supported, and a static input picks one of them.

- **Split-strobe parallel style:** separate active-low read and write strobes.
- **Data-strobe parallel style:** a single active-low data strobe plus a read/not-write direction line.
- **Serial style:** a 16-bit frame shifted in on a serial clock.

In the parallel styles, a further input selects the address source:

- **Multiplexed:** the address shares the data lines and is captured by an address-latch strobe.
- **Non-multiplexed:** the address arrives on a dedicated address port.

One output pin is shared between three meanings. It is a two-phase ready in the split-strobe style, an acknowledge in the data-strobe style, and serial read data in the serial style. It is modelled as a value plus an output enable, and it is left undriven whenever no bus cycle is in progress.

All host controls pass through a two-flop synchronizer into the internal clock domain. A parallel access completes a fixed number of internal clock cycles (`ACK_DLY`, default 2) after the pin starts being driven. The register bank holds `NREGS` (default 24) 8-bit registers, which reset to zero.

Parallel addresses are 5 bits and serial addresses are 7 bits. Any address at or above `NREGS` lies outside the bank.

Top module: `hri_host_if`

## Requirements
- R1: After reset, `rdy_oe` and `ad_oe` are 0 and every register reads back 0x00.
- R2: With `host_style`=0, an access drives `rdy_oe`=1 with `rdy_o`=0. `rdy_o` then rises exactly `ACK_DLY` clocks later. For a read (`rd_n` low), `ad_oe`=1 at that point and `ad_out` holds the register value. For a write (`wr_n` low), `ad_in` is stored.
- R3: With `host_style`=1 and `rnw`=1, the pin is driven low and rises exactly `ACK_DLY` clocks later. At that point `ad_oe`=1 and `ad_out` carries the register value.
- R4: With `host_style`=1 and `rnw`=0, the pin is driven high and falls exactly `ACK_DLY` clocks later. At that point `ad_in` has been stored in the addressed register.
- R5: After `cs_n` and the strobes go inactive, `rdy_oe` and `ad_oe` return to 0 within 5 clocks. This applies in every style, and in the serial style it happens once `cs_n` rises.
- R6: With `mux_mode`=1, the register address is `ad_in[4:0]` captured at the falling edge of `ale_n`, and the `addr` port is ignored. With `mux_mode`=0, the address comes from `addr`.
- R7: With `no_wait`=1, `rdy_oe` stays 0 throughout parallel accesses. Reads still present data on `ad_out` with `ad_oe`=1, and writes still take effect.
- R8: With `host_style`=2 and `cs_n` low, a serial frame is sent MSB first and consists of:
  - one direction bit (1 = read, 0 = write);
  - a 7-bit address;
  - 8 data bits.

  On a write, the data is stored after the 16th bit.
- R9: In a serial read, the pin carries the 8 register bits MSB first. A new bit appears after each falling `sclk` edge when `clk_edge_sel`=0, or after each rising edge when `clk_edge_sel`=1. Input bits are sampled on the opposite edge.
- R10: In serial mode, `rdy_oe` stays 0 for the whole of a write frame and for the direction and address bits of a read frame.
- R11: Addresses at or above `NREGS` read 0x00, and writes to them change no register.
- R12: An `ale_n` falling edge seen in the same cycle as the strobe assertion uses the newly presented address.
- R13: A parallel write whose strobe is withdrawn before completion leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_style | input | 2 | 0 split strobes, 1 data strobe with direction, 2 or 3 serial |
| mux_mode | input | 1 | 1 selects a multiplexed address/data bus |
| no_wait | input | 1 | 1 suppresses driving of the ready/acknowledge pin |
| clk_edge_sel | input | 1 | Serial output edge: 0 falling, 1 rising |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe (split style) |
| wr_n | input | 1 | Write strobe (split style) |
| ds_n | input | 1 | Data strobe (data-strobe style) |
| rnw | input | 1 | Direction, 1 read (data-strobe style) |
| ale_n | input | 1 | Address latch strobe (multiplexed) |
| addr | input | 5 | Address (non-multiplexed) |
| ad_in | input | 8 | Data, or address when multiplexed |
| ad_out | output | 8 | Read data |
| ad_oe | output | 1 | Enable for ad_out |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| rdy_o | output | 1 | Shared ready/acknowledge/serial-out value |
| rdy_oe | output | 1 | Enable for rdy_o, 0 means high impedance |

## Verification
In the multiplexed style, the capture of an address on the `ale_n` falling edge and the start of an access can land in the same internal clock. The bench provokes this by first latching one address and then presenting a different address on `ad_in`. In the same cycle it lowers `ale_n` and asserts `cs_n` and `rd_n` together, so both pass through the synchronizer side by side. The read is judged correct only if `ad_out` returns the contents of the newly presented address rather than the previously latched one.

// File: rtl/hri_pkg.sv
package hri_pkg;
  localparam logic [1:0] STYLE_SPLIT = 2'd0;
  localparam logic [1:0] STYLE_DSTRB = 2'd1;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_WAIT = 2'd1,
    PS_DONE = 2'd2
  } pstate_e;
endpackage

// File: rtl/hri_sync.sv
module hri_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      logic meta, hold;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta <= RSTV[g];
          hold <= RSTV[g];
        end else begin
          meta <= d[g];
          hold <= meta;
        end
      end
      assign q[g] = hold;
    end
  endgenerate
endmodule

// File: rtl/hri_regfile.sv
module hri_regfile #(
  parameter int NREGS = 24,
  parameter int DW    = 8,
  parameter int RAW   = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] raddr_a,
  output logic [DW-1:0]  rdata_a,
  input  logic [RAW-1:0] raddr_b,
  output logic [DW-1:0]  rdata_b
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [RAW-1:0] LIMIT = RAW'(NREGS);

  logic [DW-1:0] ent [NREGS];

  generate
    for (genvar g = 0; g < NREGS; g++) begin : g_ent
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (we && waddr == RAW'(g)) q <= wdata;
      end
      assign ent[g] = q;
    end
  endgenerate

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    if (raddr_a < LIMIT) rdata_a = ent[raddr_a[IW-1:0]];
    if (raddr_b < LIMIT) rdata_b = ent[raddr_b[IW-1:0]];
  end

  // Writes outside the bank must not appear on either read port next cycle.
  AST_OOR_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr >= LIMIT && raddr_a == waddr) |=> (rdata_a == '0)); // R11
endmodule

// File: rtl/hri_par_engine.sv
module hri_par_engine
  import hri_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PAW     = 5,
  parameter int ACK_DLY = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           dstrb,
  input  logic           mux_mode,
  input  logic           cs_n_s,
  input  logic           rd_n_s,
  input  logic           wr_n_s,
  input  logic           ds_n_s,
  input  logic           rnw_s,
  input  logic           ale_n_s,
  input  logic [PAW-1:0] addr_in,
  input  logic [DW-1:0]  data_in,
  input  logic [DW-1:0]  rf_rdata,
  output logic [PAW-1:0] rf_addr,
  output logic           rf_we,
  output logic [DW-1:0]  rf_wdata,
  output logic           pin_act,
  output logic           pin_val,
  output logic           dbus_oe,
  output logic [DW-1:0]  dbus_out
);
  localparam int CW = $clog2(ACK_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_DLY - 1);

  pstate_e        state;
  logic [CW-1:0]  cnt;
  logic           acc_rd;
  logic [PAW-1:0] acc_addr;
  logic           act_s, act_q, start, start_rd;
  logic           ale_q, ale_fall;
  logic [PAW-1:0] lat_addr, eff_addr;
  logic           done;

  // Strobe qualification differs between the two parallel styles.
  always_comb begin
    if (dstrb) begin
      act_s    = en && !cs_n_s && !ds_n_s;
      start_rd = rnw_s;
    end else begin
      act_s    = en && !cs_n_s && (!rd_n_s || !wr_n_s);
      start_rd = !rd_n_s;
    end
  end

  assign start    = act_s && !act_q && (state == PS_IDLE);
  assign ale_fall = ale_q && !ale_n_s;
  // A latch edge in the same cycle as the start forwards the fresh address.
  assign eff_addr = mux_mode ? (ale_fall ? data_in[PAW-1:0] : lat_addr) : addr_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q    <= 1'b1;
      lat_addr <= '0;
      act_q    <= 1'b0;
    end else begin
      ale_q <= ale_n_s;
      act_q <= act_s;
      if (ale_fall) lat_addr <= data_in[PAW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_IDLE;
      cnt      <= '0;
      acc_rd   <= 1'b0;
      acc_addr <= '0;
      dbus_out <= '0;
    end else begin
      unique case (state)
        PS_IDLE: begin
          if (start) begin
            state    <= PS_WAIT;
            cnt      <= '0;
            acc_rd   <= start_rd;
            acc_addr <= eff_addr;
          end
        end
        PS_WAIT: begin
          if (!act_s) begin
            state <= PS_IDLE;
          end else if (cnt == LAST) begin
            state    <= PS_DONE;
            dbus_out <= rf_rdata;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PS_DONE: begin
          if (!act_s) state <= PS_IDLE;
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  assign done     = (state == PS_DONE);
  assign rf_addr  = acc_addr;
  assign rf_we    = (state == PS_WAIT) && act_s && (cnt == LAST) && !acc_rd;
  assign rf_wdata = data_in;
  assign pin_act  = (state != PS_IDLE);
  assign pin_val  = dstrb ? (acc_rd ? done : !done) : done;
  assign dbus_oe  = done && acc_rd;

  AST_DONE_VIA_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_DONE && $past(state) != PS_DONE) |-> $past(state) == PS_WAIT); // R2
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !act_s |=> (state == PS_IDLE)); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PS_IDLE && $past(state) != PS_IDLE) |-> $stable(acc_addr)); // R6
endmodule

// File: rtl/hri_ser_engine.sv
module hri_ser_engine #(
  parameter int DW  = 8,
  parameter int SAW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           edge_sel,
  input  logic           cs_n_s,
  input  logic           sclk_s,
  input  logic           sdi_s,
  input  logic [DW-1:0]  rf_rdata,
  output logic [SAW-1:0] rf_addr,
  output logic           rf_we,
  output logic [DW-1:0]  rf_wdata,
  output logic           sdo,
  output logic           sdo_oe
);
  localparam int FRAME = 1 + SAW + DW;
  localparam int BCW   = $clog2(FRAME + 1);
  localparam int SRW   = (SAW > DW - 1) ? SAW : DW - 1;
  localparam logic [BCW-1:0] HDR_LAST = BCW'(SAW);
  localparam logic [BCW-1:0] DAT_LAST = BCW'(FRAME - 1);
  localparam logic [BCW-1:0] FULL     = BCW'(FRAME);

  logic           sclk_q, rise, fall, smp, drv, act;
  logic [BCW-1:0] bitcnt;
  logic [SRW-1:0] sr;
  logic           hdr_valid, hdr_rw;
  logic [SAW-1:0] hdr_addr;
  logic [DW-1:0]  osr;

  assign rise = sclk_s && !sclk_q;
  assign fall = !sclk_s && sclk_q;
  assign drv  = edge_sel ? rise : fall;
  assign smp  = edge_sel ? fall : rise;
  assign act  = en && !cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      sr        <= '0;
      hdr_valid <= 1'b0;
      hdr_rw    <= 1'b0;
      hdr_addr  <= '0;
      osr       <= '0;
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
    end else if (!act) begin
      bitcnt    <= '0;
      hdr_valid <= 1'b0;
      sdo_oe    <= 1'b0;
      sdo       <= 1'b0;
    end else begin
      if (smp && bitcnt != FULL) begin
        sr     <= {sr[SRW-2:0], sdi_s};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == HDR_LAST) begin
          hdr_valid <= 1'b1;
          hdr_rw    <= sr[SAW-1];
          hdr_addr  <= {sr[SAW-2:0], sdi_s};
        end
      end
      if (drv && hdr_valid && hdr_rw) begin
        if (!sdo_oe) begin
          sdo_oe <= 1'b1;
          sdo    <= rf_rdata[DW-1];
          osr    <= {rf_rdata[DW-2:0], 1'b0};
        end else begin
          sdo <= osr[DW-1];
          osr <= {osr[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign rf_addr  = hdr_addr;
  assign rf_we    = act && smp && (bitcnt == DAT_LAST) && hdr_valid && !hdr_rw;
  assign rf_wdata = {sr[DW-2:0], sdi_s};

  AST_WRITE_FRAME_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_rw) |-> !sdo_oe); // R10
  AST_SINGLE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we); // R8
  AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !sdo_oe); // R5
endmodule

// File: rtl/hri_host_if.sv
module hri_host_if
  import hri_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PAW     = 5,
  parameter int SAW     = 7,
  parameter int NREGS   = 24,
  parameter int ACK_DLY = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     host_style,
  input  logic           mux_mode,
  input  logic           no_wait,
  input  logic           clk_edge_sel,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic           ds_n,
  input  logic           rnw,
  input  logic           ale_n,
  input  logic [PAW-1:0] addr,
  input  logic [DW-1:0]  ad_in,
  output logic [DW-1:0]  ad_out,
  output logic           ad_oe,
  input  logic           sclk,
  input  logic           sdi,
  output logic           rdy_o,
  output logic           rdy_oe
);
  localparam int NSYNC = 8;

  logic [NSYNC-1:0] raw_in, syn;
  logic cs_n_s, rd_n_s, wr_n_s, ds_n_s, rnw_s, ale_n_s, sclk_s, sdi_s;
  logic ser_en, par_en, dstrb;

  assign raw_in = {cs_n, rd_n, wr_n, ds_n, rnw, ale_n, sclk, sdi};

  hri_sync #(.W(NSYNC), .RSTV(8'b1111_1100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );
  assign {cs_n_s, rd_n_s, wr_n_s, ds_n_s, rnw_s, ale_n_s, sclk_s, sdi_s} = syn;

  assign ser_en = host_style[1];
  assign par_en = !host_style[1];
  assign dstrb  = (host_style == STYLE_DSTRB);

  logic [PAW-1:0] p_addr;
  logic           p_we, p_act, p_val, p_oe;
  logic [DW-1:0]  p_wdata, p_dout, rd_a, rd_b;
  logic [SAW-1:0] s_addr;
  logic           s_we, s_sdo, s_oe;
  logic [DW-1:0]  s_wdata;
  logic [SAW-1:0] p_addr_x;

  assign p_addr_x = {{(SAW-PAW){1'b0}}, p_addr};

  hri_par_engine #(.DW(DW), .PAW(PAW), .ACK_DLY(ACK_DLY)) u_par (
    .clk(clk), .rst_n(rst_n), .en(par_en), .dstrb(dstrb), .mux_mode(mux_mode),
    .cs_n_s(cs_n_s), .rd_n_s(rd_n_s), .wr_n_s(wr_n_s), .ds_n_s(ds_n_s),
    .rnw_s(rnw_s), .ale_n_s(ale_n_s), .addr_in(addr), .data_in(ad_in),
    .rf_rdata(rd_a), .rf_addr(p_addr), .rf_we(p_we), .rf_wdata(p_wdata),
    .pin_act(p_act), .pin_val(p_val), .dbus_oe(p_oe), .dbus_out(p_dout)
  );

  hri_ser_engine #(.DW(DW), .SAW(SAW)) u_ser (
    .clk(clk), .rst_n(rst_n), .en(ser_en), .edge_sel(clk_edge_sel),
    .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdi_s(sdi_s), .rf_rdata(rd_b),
    .rf_addr(s_addr), .rf_we(s_we), .rf_wdata(s_wdata),
    .sdo(s_sdo), .sdo_oe(s_oe)
  );

  hri_regfile #(.NREGS(NREGS), .DW(DW), .RAW(SAW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(p_we || s_we),
    .waddr(s_we ? s_addr : p_addr_x),
    .wdata(s_we ? s_wdata : p_wdata),
    .raddr_a(p_addr_x), .rdata_a(rd_a),
    .raddr_b(s_addr), .rdata_b(rd_b)
  );

  assign rdy_oe = ser_en ? s_oe : (p_act && !no_wait);
  assign rdy_o  = ser_en ? s_sdo : p_val;
  assign ad_oe  = p_oe;
  assign ad_out = p_dout;

  AST_DATA_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && !no_wait) |-> (rdy_oe && rdy_o)); // R3
  AST_SERIAL_NO_DBUS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_style[1] && $past(host_style[1])) |-> !ad_oe); // R8
endmodule

// File: tb/hri_host_if_test.sv
`timescale 1ns/1ps
module hri_host_if_test;
  localparam int ACK_DLY = 2;
  localparam int NREGS   = 24;
  localparam int H       = 6;
  localparam int NV      = 11;

  // {style(2), mux(1), write(1), addr(5), wdata(8), expected read(8)}
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b1, 5'd3,  8'hA5, 8'h00},
    {2'd0, 1'b0, 1'b0, 5'd3,  8'h00, 8'hA5},
    {2'd1, 1'b0, 1'b1, 5'd7,  8'h3C, 8'h00},
    {2'd1, 1'b0, 1'b0, 5'd7,  8'h00, 8'h3C},
    {2'd0, 1'b1, 1'b1, 5'd9,  8'h81, 8'h00},
    {2'd1, 1'b1, 1'b0, 5'd9,  8'h00, 8'h81},
    {2'd1, 1'b1, 1'b1, 5'd17, 8'h5A, 8'h00},
    {2'd0, 1'b0, 1'b0, 5'd17, 8'h00, 8'h5A},
    {2'd0, 1'b0, 1'b1, 5'd26, 8'hFF, 8'h00},
    {2'd0, 1'b0, 1'b0, 5'd26, 8'h00, 8'h00},
    {2'd1, 1'b0, 1'b0, 5'd0,  8'h00, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] host_style = 2'd0;
  logic mux_mode = 0, no_wait = 0, clk_edge_sel = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, ds_n = 1, rnw = 1, ale_n = 1;
  logic [4:0] addr = '0;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out;
  logic ad_oe, sclk = 0, sdi = 0, rdy_o, rdy_oe;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit hiz_bad;

  always #4 clk = ~clk;

  hri_host_if #(.NREGS(NREGS), .ACK_DLY(ACK_DLY)) uut (
    .clk(clk), .rst_n(rst_n), .host_style(host_style), .mux_mode(mux_mode),
    .no_wait(no_wait), .clk_edge_sel(clk_edge_sel), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .ds_n(ds_n), .rnw(rnw), .ale_n(ale_n), .addr(addr),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .sclk(sclk), .sdi(sdi),
    .rdy_o(rdy_o), .rdy_oe(rdy_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic release_bus();
    cs_n = 1; rd_n = 1; wr_n = 1; ds_n = 1; rnw = 1; ale_n = 1;
  endtask

  task automatic par_xfer(input logic [1:0] st, input logic mx, input logic wr,
                          input logic [4:0] a, input logic [7:0] d, input logic nw,
                          input string tag, output logic [7:0] q);
    logic start_v;
    int n;
    bit seen;
    host_style = st; mux_mode = mx; no_wait = nw;
    q = 8'h00;
    if (mx) begin
      addr = ~a; ad_in = {3'b000, a}; ale_n = 1;
      @(negedge clk); ale_n = 0;
      repeat (4) @(negedge clk);
    end else begin
      addr = a;
    end
    ad_in = wr ? d : 8'h00;
    cs_n = 0;
    if (st == 2'd0) begin rd_n = wr; wr_n = !wr; end
    else begin rnw = !wr; ds_n = 0; end
    if (nw) begin
      seen = 0;
      repeat (10) begin @(negedge clk); if (rdy_oe) seen = 1; end
      check(!seen, "R7 pin stays undriven", int'(seen), 0);
      if (!wr) begin
        check(ad_oe == 1'b1, "R7 data enable", int'(ad_oe), 1);
        q = ad_out;
      end
    end else begin
      n = 0;
      while (!rdy_oe && n < 20) begin @(negedge clk); n++; end
      start_v = (st == 2'd1) && wr;
      check(rdy_oe && rdy_o == start_v, tag, int'(rdy_o), int'(start_v));
      n = 0;
      while (rdy_o == start_v && n < 20) begin @(negedge clk); n++; end
      check(n == ACK_DLY, {tag, " completion delay"}, n, ACK_DLY);
      if (!wr) begin
        check(ad_oe == 1'b1, {tag, " data enable"}, int'(ad_oe), 1);
        q = ad_out;
      end
    end
    release_bus();
    repeat (5) @(negedge clk);
    check(!rdy_oe && !ad_oe, "R5 release", int'({rdy_oe, ad_oe}), 0);
  endtask

  task automatic wait_mon(input int n, input bit mon);
    repeat (n) begin
      @(negedge clk);
      if (mon && rdy_oe) hiz_bad = 1;
    end
  endtask

  task automatic ser_frame(input bit sel, input bit rw, input logic [6:0] a,
                           input logic [7:0] d, output logic [7:0] q);
    logic [15:0] fr;
    fr = {rw, a, d};
    q = 8'h00;
    hiz_bad = 0;
    host_style = 2'd2; clk_edge_sel = sel; sclk = 0;
    cs_n = 0;
    wait_mon(H, 1);
    for (int i = 0; i < 16; i++) begin
      sdi = fr[15-i];
      wait_mon(H, !rw || i < 7);
      sclk = 1;
      wait_mon(H, !rw || i < 7);
      if (sel && rw && i >= 8) q[15-i] = rdy_o;
      sclk = 0;
      wait_mon(H, !rw || i < 7);
      if (!sel && rw && i >= 7 && i <= 14) q[14-i] = rdy_o;
    end
    cs_n = 1;
    repeat (5) @(negedge clk);
    check(!rdy_oe, "R5 serial release", int'(rdy_oe), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!rdy_oe && !ad_oe, "R1 reset outputs", int'({rdy_oe, ad_oe}), 0);

    foreach (VEC[k]) begin
      logic [1:0] st; logic mx, wr; logic [4:0] a; logic [7:0] d, e;
      {st, mx, wr, a, d, e} = VEC[k];
      if (a >= NREGS) tag = "R11";
      else if (a == 0) tag = "R1";
      else if (mx) tag = "R6";
      else if (st == 2'd0) tag = "R2";
      else if (wr) tag = "R4";
      else tag = "R3";
      par_xfer(st, mx, wr, a, d, 1'b0, tag, q);
      if (!wr) check(q == e, {tag, " read data"}, q, e);
    end

    // R7: no handshake on the pin, accesses still complete
    par_xfer(2'd1, 1'b0, 1'b1, 5'd4, 8'h66, 1'b1, "R7", q);
    par_xfer(2'd0, 1'b0, 1'b0, 5'd4, 8'h00, 1'b1, "R7", q);
    check(q == 8'h66, "R7 read data", q, 8'h66);

    // R13: one-cycle write strobe is withdrawn before completion
    host_style = 2'd0; mux_mode = 0; no_wait = 0; addr = 5'd5; ad_in = 8'h99;
    cs_n = 0; wr_n = 0;
    @(negedge clk);
    release_bus();
    repeat (6) @(negedge clk);
    par_xfer(2'd0, 1'b0, 1'b0, 5'd5, 8'h00, 1'b0, "R13", q);
    check(q == 8'h00, "R13 aborted write", q, 0);

    // R12: address latch edge coincides with the read strobe
    host_style = 2'd0; mux_mode = 1; addr = 5'd0;
    ad_in = 8'd9; ale_n = 1;
    @(negedge clk); ale_n = 0;
    repeat (4) @(negedge clk); ale_n = 1;
    repeat (4) @(negedge clk);
    ad_in = 8'd3;
    ale_n = 0; cs_n = 0; rd_n = 0;
    begin
      int n;
      n = 0;
      while (!ad_oe && n < 20) begin @(negedge clk); n++; end
    end
    check(ad_out == 8'hA5, "R12 same-cycle latch", ad_out, 8'hA5);
    release_bus();
    repeat (6) @(negedge clk);

    // R8/R9/R10: serial frames, both output edges
    ser_frame(1'b0, 1'b0, 7'd10, 8'hC3, q);
    check(!hiz_bad, "R10 write frame undriven", int'(hiz_bad), 0);
    ser_frame(1'b0, 1'b1, 7'd10, 8'h00, q);
    check(q == 8'hC3, "R9 read falling-edge output", q, 8'hC3);
    check(!hiz_bad, "R10 read header undriven", int'(hiz_bad), 0);
    ser_frame(1'b1, 1'b1, 7'd10, 8'h00, q);
    check(q == 8'hC3, "R9 read rising-edge output", q, 8'hC3);
    ser_frame(1'b1, 1'b0, 7'd11, 8'h12, q);
    check(!hiz_bad, "R10 write frame undriven", int'(hiz_bad), 0);
    par_xfer(2'd0, 1'b0, 1'b0, 5'd11, 8'h00, 1'b0, "R8", q);
    check(q == 8'h12, "R8 serial write stored", q, 8'h12);
    ser_frame(1'b0, 1'b0, 7'd100, 8'h77, q);
    ser_frame(1'b0, 1'b1, 7'd100, 8'h00, q);
    check(q == 8'h00, "R11 serial out-of-range", q, 0);
    ser_frame(1'b0, 1'b1, 7'd3, 8'h00, q);
    check(q == 8'hA5, "R8 serial read of parallel data", q, 8'hA5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule